// File: doc/BRIEF.md
# Sector Clock and Set/Reset Selector

This block selects the clock and set/reset feeding every sector of a cell array. The array is built from columns, and each column is split into sectors of four cells. Each column first picks one clock from a shared set of global clocks. The two outermost columns can also pick one of two fast clocks reserved for their side. Each sector then chooses between its column clock and a clock routed in locally. It passes that clock unchanged, passes it inverted, or ties it to 0 so that an unused sector stays quiet. In parallel, each sector picks its set/reset from the single array-wide reset or a locally routed reset, and passes it unchanged or inverted. The reset path has no tie-off.

All selections are static. Software writes them through a small register port while `cfg_done` is low. The block copies them into the active set when `cfg_done` is first seen high. Until then, every sector clock is held at 0 and every sector reset is held at 1.

Top module: `sector_clock_dist`

## Requirements
- R1: After `rst` has been high for at least one clock edge, every `sec_clk` bit is 0 and every `sec_rst` bit is 1.
- R2: A write with `cfg_we` high is stored in the staging registers only when `cfg_done` is low. A write made while `cfg_done` is high changes nothing, including the configuration used after a later low-to-high transition of `cfg_done`.
- R3: The block becomes live at the clock edge where `cfg_done` is first sampled high, and at that edge it loads the staged values into the active set. Sector clocks are 0 whenever the block is not live, and it stops being live at the first edge where `cfg_done` is sampled low.
- R4: With column select code k, for k from 0 to `NUM_GCLK-1`, the column clock is `gclk[k]`.
- R5: On column 0, codes `NUM_GCLK` and `NUM_GCLK+1` (8 and 9 by default) select `fclk[0]` and `fclk[1]`. On the last column, the same codes select `fclk[2]` and `fclk[3]`. On interior columns these codes, and any larger code, give a constant 0 column clock.
- R6: Sector configuration bit 2 chooses the sector clock source: 0 selects the sector's column clock, and 1 selects `bus_clk[i]`, where i = column*`NUM_SECTORS` + sector.
- R7: Sector configuration bits [1:0] set the clock mode: 1 passes the source true, 2 passes it inverted, and 0 or 3 forces the output to 0.
- R8: When live, bit 3 of the sector configuration chooses the reset source (0 selects `grst`, 1 selects `bus_rst[i]`), and bit 4 inverts it. No code forces the reset to a constant.
- R9: While the block is not live, every `sec_rst` bit is 1.
- R10: The write address is column*2^`SLOT_W` + slot. Slot 0 is the column select register (bits [3:0]). Slots 1 to `NUM_SECTORS` are the sector registers, for sector slot-1. Writes to any other slot are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W (5) | Write address {column, slot} |
| cfg_wdata | input | DW (5) | Write data |
| cfg_done | input | 1 | High when configuration is complete |
| gclk | input | NUM_GCLK (8) | Global clocks |
| fclk | input | 4 | Fast clocks: [1:0] for the left edge, [3:2] for the right edge |
| bus_clk | input | NCS (16) | Locally routed clock for each sector |
| grst | input | 1 | Single global set/reset |
| bus_rst | input | NCS (16) | Locally routed reset for each sector |
| sec_clk | output | NCS (16) | Selected clock for each sector |
| sec_rst | output | NCS (16) | Selected set/reset for each sector |

## Verification
The hardest case to reach from the ports is the interaction between the two configuration layers. A write made after `cfg_done` has gone high must stay invisible even after `cfg_done` drops and rises again. Reaching this takes a full configure, go live, write, reconfigure cycle. Separately, the fast-clock codes must be driven on edge and interior columns at the same time. The stimulus runs 32 phases. Each phase writes one column code to every column and rotates all 32 sector codes across the sectors. Every fourth phase adds writes during the live period, and every phase adds writes to unused slots. Meanwhile all clock and reset inputs toggle randomly on every cycle, and every output bit is compared against a behavioural model on each clock.

// File: rtl/scd_pkg.sv
package scd_pkg;

  typedef enum logic [1:0] {
    CK_OFF  = 2'd0,
    CK_TRUE = 2'd1,
    CK_INV  = 2'd2,
    CK_OFF2 = 2'd3
  } ck_mode_e;

  // bit 4: invert reset, bit 3: routed reset, bit 2: routed clock, bits 1:0: mode
  typedef struct packed {
    logic     rst_inv;
    logic     rst_routed;
    logic     clk_routed;
    ck_mode_e mode;
  } sec_cfg_t;

  localparam int SEC_CFG_W = $bits(sec_cfg_t);

endpackage

// File: rtl/scd_cfg_regs.sv
module scd_cfg_regs
  import scd_pkg::*;
#(
  parameter int NUM_COLS    = 4,
  parameter int NUM_SECTORS = 4,
  parameter int CSEL_W      = 4,
  parameter int COL_W       = 2,
  parameter int SLOT_W      = 3,
  parameter int DW          = 5,
  localparam int NCS        = NUM_COLS * NUM_SECTORS
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [COL_W+SLOT_W-1:0]          cfg_addr,
  input  logic [DW-1:0]                    cfg_wdata,
  input  logic                             cfg_done,
  output logic                             live,
  output logic [NUM_COLS-1:0][CSEL_W-1:0]  col_act,
  output sec_cfg_t [NCS-1:0]               sec_act
);

  logic [NUM_COLS-1:0][CSEL_W-1:0] col_stage;
  sec_cfg_t [NCS-1:0]              sec_stage;
  logic [COL_W-1:0]                wr_col;
  logic [SLOT_W-1:0]               wr_slot;

  assign wr_col  = cfg_addr[COL_W+SLOT_W-1:SLOT_W];
  assign wr_slot = cfg_addr[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      col_stage <= '0;
      sec_stage <= '0;
      col_act   <= '0;
      sec_act   <= '0;
      live      <= 1'b0;
    end else begin
      if (cfg_we && !cfg_done) begin
        for (int c = 0; c < NUM_COLS; c++) begin
          if (int'(wr_col) == c) begin
            if (wr_slot == '0) col_stage[c] <= cfg_wdata[CSEL_W-1:0];
            for (int s = 0; s < NUM_SECTORS; s++) begin
              if (int'(wr_slot) == s + 1)
                sec_stage[c*NUM_SECTORS+s] <= sec_cfg_t'(cfg_wdata[SEC_CFG_W-1:0]);
            end
          end
        end
      end
      if (cfg_done && !live) begin
        col_act <= col_stage;
        sec_act <= sec_stage;
      end
      live <= cfg_done;
    end
  end

  AST_LIVE_RISE: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> live); // R3
  AST_LIVE_FALL: assert property (@(posedge clk) disable iff (rst)
    !cfg_done |=> !live); // R3
  AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (live && cfg_done) |=> ($stable(sec_act) && $stable(col_act))); // R2

endmodule

// File: rtl/scd_col_mux.sv
module scd_col_mux #(
  parameter int NUM_GCLK = 8,
  parameter int CSEL_W   = 4,
  parameter bit HAS_FAST = 1'b0,
  localparam int GSEL_W  = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1
) (
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic [1:0]          fclk,
  input  logic [CSEL_W-1:0]   sel,
  output logic                col_clk
);

  always_comb begin
    col_clk = 1'b0;
    if (int'(sel) < NUM_GCLK) begin
      col_clk = gclk[sel[GSEL_W-1:0]];
    end else if (HAS_FAST) begin
      if (int'(sel) == NUM_GCLK)          col_clk = fclk[0];
      else if (int'(sel) == NUM_GCLK + 1) col_clk = fclk[1];
    end
  end

endmodule

// File: rtl/scd_sector_mux.sv
module scd_sector_mux
  import scd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     live,
  input  sec_cfg_t cfg,
  input  logic     col_clk,
  input  logic     bus_clk,
  input  logic     grst,
  input  logic     bus_rst,
  output logic     clk_out,
  output logic     rst_out
);

  logic src_clk;
  logic src_rst;

  assign src_clk = cfg.clk_routed ? bus_clk : col_clk;
  assign src_rst = cfg.rst_routed ? bus_rst : grst;

  always_comb begin
    clk_out = 1'b0;
    if (live) begin
      case (cfg.mode)
        CK_TRUE: clk_out = src_clk;
        CK_INV:  clk_out = ~src_clk;
        default: clk_out = 1'b0;
      endcase
    end
  end

  assign rst_out = live ? (src_rst ^ cfg.rst_inv) : 1'b1;

  AST_CLK_HELD: assert property (@(posedge clk) disable iff (rst)
    !live |-> !clk_out); // R3
  AST_TIE_OFF: assert property (@(posedge clk) disable iff (rst)
    (live && (cfg.mode == CK_OFF || cfg.mode == CK_OFF2)) |-> !clk_out); // R7
  AST_RST_HELD: assert property (@(posedge clk) disable iff (rst)
    !live |-> rst_out); // R9
  AST_RST_NO_TIE: assert property (@(posedge clk) disable iff (rst)
    (live && !cfg.rst_routed && $changed(grst) && $stable(cfg) && $stable(live)) |-> $changed(rst_out)); // R8

endmodule

// File: rtl/sector_clock_dist.sv
module sector_clock_dist
  import scd_pkg::*;
#(
  parameter int NUM_COLS    = 4,
  parameter int NUM_SECTORS = 4,
  parameter int NUM_GCLK    = 8,
  localparam int NCS        = NUM_COLS * NUM_SECTORS,
  localparam int CSEL_W     = $clog2(NUM_GCLK + 2),
  localparam int COL_W      = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int SLOT_W     = $clog2(NUM_SECTORS + 1),
  localparam int ADDR_W     = COL_W + SLOT_W,
  localparam int DW         = (CSEL_W > SEC_CFG_W) ? CSEL_W : SEC_CFG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DW-1:0]       cfg_wdata,
  input  logic                cfg_done,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic [3:0]          fclk,
  input  logic [NCS-1:0]      bus_clk,
  input  logic                grst,
  input  logic [NCS-1:0]      bus_rst,
  output logic [NCS-1:0]      sec_clk,
  output logic [NCS-1:0]      sec_rst
);

  logic                            live;
  logic [NUM_COLS-1:0][CSEL_W-1:0] col_act;
  sec_cfg_t [NCS-1:0]              sec_act;
  logic [NUM_COLS-1:0]             col_clk;

  scd_cfg_regs #(
    .NUM_COLS(NUM_COLS), .NUM_SECTORS(NUM_SECTORS), .CSEL_W(CSEL_W),
    .COL_W(COL_W), .SLOT_W(SLOT_W), .DW(DW)
  ) i_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_done(cfg_done), .live(live),
    .col_act(col_act), .sec_act(sec_act)
  );

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    if (c == 0) begin : g_left
      scd_col_mux #(.NUM_GCLK(NUM_GCLK), .CSEL_W(CSEL_W), .HAS_FAST(1'b1)) i_cmux (
        .gclk(gclk), .fclk(fclk[1:0]), .sel(col_act[c]), .col_clk(col_clk[c]));
    end else if (c == NUM_COLS - 1) begin : g_right
      scd_col_mux #(.NUM_GCLK(NUM_GCLK), .CSEL_W(CSEL_W), .HAS_FAST(1'b1)) i_cmux (
        .gclk(gclk), .fclk(fclk[3:2]), .sel(col_act[c]), .col_clk(col_clk[c]));
    end else begin : g_mid
      scd_col_mux #(.NUM_GCLK(NUM_GCLK), .CSEL_W(CSEL_W), .HAS_FAST(1'b0)) i_cmux (
        .gclk(gclk), .fclk(2'b00), .sel(col_act[c]), .col_clk(col_clk[c]));
    end

    for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sec
      localparam int IDX = c * NUM_SECTORS + s;
      scd_sector_mux i_smux (
        .clk(clk), .rst(rst), .live(live), .cfg(sec_act[IDX]),
        .col_clk(col_clk[c]), .bus_clk(bus_clk[IDX]),
        .grst(grst), .bus_rst(bus_rst[IDX]),
        .clk_out(sec_clk[IDX]), .rst_out(sec_rst[IDX]));
    end
  end

  AST_ALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !live |-> ($countones(sec_clk) == 0)); // R3
  AST_ALL_RST: assert property (@(posedge clk) disable iff (rst)
    !live |-> (sec_rst == '1)); // R9

endmodule

// File: tb/test_sector_clock_dist.sv
module test_sector_clock_dist;

  localparam int NC = 4;
  localparam int NS = 4;
  localparam int NG = 8;
  localparam int NX = NC * NS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [4:0]    cfg_addr = '0;
  logic [4:0]    cfg_wdata = '0;
  logic          cfg_done = 1'b0;
  logic [NG-1:0] gclk = '0;
  logic [3:0]    fclk = '0;
  logic [NX-1:0] bus_clk = '0;
  logic          grst = 1'b0;
  logic [NX-1:0] bus_rst = '0;
  logic [NX-1:0] sec_clk;
  logic [NX-1:0] sec_rst;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit cmp_on = 0;
  bit done_flag = 0;

  int ref_col_stage[NC];
  int ref_col_act[NC];
  int ref_sec_stage[NX];
  int ref_sec_act[NX];
  bit ref_live;

  sector_clock_dist i_sector_clock_dist (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_done(cfg_done), .gclk(gclk), .fclk(fclk),
    .bus_clk(bus_clk), .grst(grst), .bus_rst(bus_rst),
    .sec_clk(sec_clk), .sec_rst(sec_rst)
  );

  always #4 clk = ~clk;

  // reference model, updated on every edge from the sampled inputs
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int c = 0; c < NC; c++) begin ref_col_stage[c] = 0; ref_col_act[c] = 0; end
      for (int i = 0; i < NX; i++) begin ref_sec_stage[i] = 0; ref_sec_act[i] = 0; end
      ref_live = 0;
      cmp_on = 1;
    end else begin
      if (cfg_done && !ref_live) begin
        for (int c = 0; c < NC; c++) ref_col_act[c] = ref_col_stage[c];
        for (int i = 0; i < NX; i++) ref_sec_act[i] = ref_sec_stage[i];
      end
      if (cfg_we && !cfg_done) begin
        int col;
        int slot;
        col  = int'(cfg_addr) / 8;
        slot = int'(cfg_addr) % 8;
        if (slot == 0) ref_col_stage[col] = int'(cfg_wdata) % 16;
        else if (slot <= NS) ref_sec_stage[col*NS + slot - 1] = int'(cfg_wdata);
      end
      ref_live = cfg_done;
    end
  end

  // random toggling of every clock and reset input
  always @(posedge clk) begin
    #1;
    gclk    <= NG'($urandom);
    fclk    <= 4'($urandom);
    bus_clk <= NX'($urandom);
    bus_rst <= NX'($urandom);
    grst    <= 1'($urandom);
  end

  function automatic bit exp_clk(int i);
    int  c;
    int  code;
    int  v;
    bit  colc;
    bit  src;
    c    = i / NS;
    code = ref_col_act[c];
    v    = ref_sec_act[i];
    colc = 1'b0;
    if (code < NG) colc = gclk[code];
    else if (code == NG || code == NG + 1) begin
      if (c == 0) colc = fclk[code - NG];
      else if (c == NC - 1) colc = fclk[2 + code - NG];
    end
    src = ((v >> 2) & 1) != 0 ? bus_clk[i] : colc;
    if (!ref_live) return 1'b0;
    if ((v & 3) == 1) return src;
    if ((v & 3) == 2) return ~src;
    return 1'b0;
  endfunction

  function automatic bit exp_rst(int i);
    int v;
    bit src;
    v = ref_sec_act[i];
    if (!ref_live) return 1'b1;
    src = ((v >> 3) & 1) != 0 ? bus_rst[i] : grst;
    return src ^ (((v >> 4) & 1) != 0);
  endfunction

  function automatic string clk_tag(int i);
    int v;
    v = ref_sec_act[i];
    if (!ref_live) return "R3";
    if ((v & 3) != 1) return "R7";
    if (((v >> 2) & 1) != 0) return "R6";
    if (ref_col_act[i / NS] < NG) return "R4";
    return "R5";
  endfunction

  task automatic compare_all(string force_tag);
    for (int i = 0; i < NX; i++) begin
      string t;
      checks++;
      t = (force_tag != "") ? force_tag : clk_tag(i);
      if (sec_clk[i] !== exp_clk(i)) begin
        errors++;
        $display("FAIL %s sec_clk[%0d] actual=%b expected=%b", t, i, sec_clk[i], exp_clk(i));
      end
      checks++;
      t = (force_tag != "") ? force_tag : (ref_live ? "R8" : "R9");
      if (sec_rst[i] !== exp_rst(i)) begin
        errors++;
        $display("FAIL %s sec_rst[%0d] actual=%b expected=%b", t, i, sec_rst[i], exp_rst(i));
      end
    end
  endtask

  always @(negedge clk) if (cmp_on && !done_flag) compare_all("");

  task automatic cfg_write(int addr, int data);
    @(posedge clk); #1;
    cfg_we    = 1'b1;
    cfg_addr  = 5'(addr);
    cfg_wdata = 5'(data);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic check_vec(string tag);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (sec_clk !== '0 || sec_rst !== '1) begin
      errors++;
      $display("FAIL R1 after reset actual clk=%h rst=%h expected clk=0000 rst=ffff", sec_clk, sec_rst);
    end

    for (int ph = 0; ph < 32; ph++) begin
      for (int c = 0; c < NC; c++) cfg_write(c * 8, ph % 16);
      for (int i = 0; i < NX; i++) cfg_write((i / NS) * 8 + (i % NS) + 1, (i + ph) % 32);
      cfg_write((ph % NC) * 8 + 7, 31 - ph);  // unused slot, R10
      cfg_write((ph % NC) * 8 + 5, ph);       // unused slot, R10
      @(posedge clk); #1 cfg_done = 1'b1;
      repeat (20) @(posedge clk);
      check_vec("R10");
      if (ph % 4 == 0) begin
        // writes while configured must not reach staging: R2
        for (int c = 0; c < NC; c++) cfg_write(c * 8, 15 - (ph % 16));
        cfg_write(1, 5'h1f);
        cfg_write(NC * 8 - 8 + 2, 5'h06);
        @(posedge clk); #1 cfg_done = 1'b0;
        repeat (3) @(posedge clk);
        #1 cfg_done = 1'b1;
        repeat (10) @(posedge clk);
        check_vec("R2");
      end
      @(posedge clk); #1 cfg_done = 1'b0;
      repeat (3) @(posedge clk);
      check_vec("R3");
    end

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 30000);
    if (!done_flag) begin
      done_flag = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete actual=%0d expected<30000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule